// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit turns an operand reference into a 20-bit physical memory address. An offset is built from up to three terms: a displacement, a base register value and an index register value. A 16-bit segment value is then selected, shifted left by four bit positions and added to that offset. The segment is either the default for the addressing combination or one that the caller names explicitly.

A caller presents the register values, the addressing selectors and the four segment register values, and asserts a one-cycle input strobe. One clock later, the unit presents the physical address, the 16-bit effective address and a code for the segment that was used, together with a one-cycle valid pulse. If the combination of selectors is not one of the seventeen legal ones, the unit raises a one-cycle error pulse instead of the valid pulse.

Top module: `seg_addr_gen`

## Requirements
- R1: The effective address is the sum of the terms that are present. `base_kind` selects the base term: 0 none, 1 general base, 2 frame base. `idx_kind` selects the index term: 0 none, 1 source, 2 destination. `disp_en`=1 adds the displacement term.
- R2: When another term is present, `disp_wide`=0 takes bits 7:0 of `disp_val` and sign-extends them to 16 bits, and `disp_wide`=1 takes all 16 bits.
- R3: In the displacement-only mode (`base_kind`=0, `idx_kind`=0, `disp_en`=1), all 16 bits of `disp_val` are used and `disp_wide` has no effect.
- R4: The effective-address sum wraps modulo 2^16, so any carry out of bit 15 is lost.
- R5: Without an override, a mode that uses the frame base (`base_kind`=2) selects the stack segment, and every other mode selects the data segment. `seg_used` encodes the segment as 0 data, 1 stack, 2 code, 3 extra.
- R6: When `ovr_en`=1, the segment coded by `ovr_sel` (same encoding as `seg_used`) replaces the default segment.
- R7: `phys_addr` equals the selected segment value times 16 plus the effective address, modulo 2^20.
- R8: For a legal mode, inputs sampled at a clock edge with `in_valid`=1 appear on the outputs after that edge. `out_valid` is then high for one cycle. `out_valid` is low after any edge at which `in_valid` was low.
- R9: For an illegal mode, `mode_err` goes high for one cycle and `out_valid` stays low. The illegal modes are: `base_kind`=3, `idx_kind`=3, or no term present at all.
- R10: After a synchronous active-low reset, `out_valid` and `mode_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input strobe, one request per high cycle |
| base_kind | input | 2 | Base term select (0 none, 1 general, 2 frame, 3 illegal) |
| idx_kind | input | 2 | Index term select (0 none, 1 source, 2 destination, 3 illegal) |
| disp_en | input | 1 | Displacement term present |
| disp_wide | input | 1 | Displacement is 16-bit (1) or sign-extended 8-bit (0) |
| base_val | input | 16 | Base register value |
| idx_val | input | 16 | Index register value |
| disp_val | input | 16 | Displacement value |
| seg_data | input | 16 | Data segment register value |
| seg_stack | input | 16 | Stack segment register value |
| seg_code | input | 16 | Code segment register value |
| seg_extra | input | 16 | Extra segment register value |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override segment code |
| out_valid | output | 1 | Result valid pulse |
| mode_err | output | 1 | Illegal mode pulse |
| phys_addr | output | 20 | Physical address |
| eff_addr | output | 16 | Effective address |
| seg_used | output | 2 | Code of the segment applied |

## Verification
The assertions assume that the inputs are stable and free of X around every sampling edge. They also assume that the register and segment values belong to the request that `in_valid` marks. They assume that the selectors may take any 2-bit value, including the reserved codes. The stimulus drives all inputs on the falling clock edge and holds them through the following rising edge. It sweeps every selector code, both displacement widths, and every override choice as well as no override. Each of these runs against operand patterns chosen so that both the 16-bit offset sum and the 20-bit physical sum wrap.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned OFS_W     = 16;
  localparam int unsigned SEG_SHIFT = 4;
  localparam int unsigned PA_W      = OFS_W + SEG_SHIFT;
  localparam int unsigned NARROW_W  = 8;
  localparam int unsigned NUM_SEG   = 4;

  typedef enum logic [1:0] {
    SEG_DATA  = 2'd0,
    SEG_STACK = 2'd1,
    SEG_CODE  = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    BASE_NONE  = 2'd0,
    BASE_GEN   = 2'd1,
    BASE_FRAME = 2'd2,
    BASE_RSVD  = 2'd3
  } base_kind_e;

  typedef enum logic [1:0] {
    IDX_NONE = 2'd0,
    IDX_SRC  = 2'd1,
    IDX_DST  = 2'd2,
    IDX_RSVD = 2'd3
  } idx_kind_e;

  // Narrow displacement: sign-extend the low byte to the offset width.
  function automatic logic [OFS_W-1:0] widen_disp(input logic [OFS_W-1:0] raw,
                                                  input logic wide);
    if (wide) return raw;
    return {{(OFS_W-NARROW_W){raw[NARROW_W-1]}}, raw[NARROW_W-1:0]};
  endfunction

  // Segment shifted into paragraph units plus the offset; the carry past PA_W is dropped.
  function automatic logic [PA_W-1:0] phys_sum(input logic [OFS_W-1:0] seg,
                                               input logic [OFS_W-1:0] ofs);
    logic [PA_W-1:0] s;
    logic [PA_W-1:0] o;
    s = {seg, {SEG_SHIFT{1'b0}}};
    o = {{SEG_SHIFT{1'b0}}, ofs};
    return s + o;
  endfunction
endpackage

// File: rtl/agu_ea.sv
module agu_ea
  import agu_pkg::*;
#(
  parameter int unsigned W = OFS_W
) (
  input  logic [1:0]   base_kind,
  input  logic [1:0]   idx_kind,
  input  logic         disp_en,
  input  logic         disp_wide,
  input  logic [W-1:0] base_val,
  input  logic [W-1:0] idx_val,
  input  logic [W-1:0] disp_val,
  output logic [W-1:0] ea,
  output logic         mode_bad,
  output logic         disp_only
);
  localparam int unsigned NTERM = 3;

  logic [NTERM-1:0] term_on;
  logic [W-1:0]     term_val [NTERM];
  logic             has_reg;
  logic             disp_full;

  assign has_reg   = (base_kind != BASE_NONE) || (idx_kind != IDX_NONE);
  assign disp_only = disp_en && !has_reg;
  assign disp_full = disp_wide || disp_only;
  assign mode_bad  = (base_kind == BASE_RSVD) || (idx_kind == IDX_RSVD) ||
                     (!has_reg && !disp_en);

  assign term_on[0]  = (base_kind == BASE_GEN) || (base_kind == BASE_FRAME);
  assign term_on[1]  = (idx_kind == IDX_SRC) || (idx_kind == IDX_DST);
  assign term_on[2]  = disp_en;
  assign term_val[0] = base_val;
  assign term_val[1] = idx_val;
  assign term_val[2] = widen_disp(disp_val, disp_full);

  // Each term is masked by its enable, then all are summed at the offset width.
  always_comb begin
    ea = '0;
    for (int k = 0; k < NTERM; k++) begin
      ea = ea + (term_on[k] ? term_val[k] : '0);
    end
  end
endmodule

// File: rtl/agu_segsel.sv
module agu_segsel
  import agu_pkg::*;
#(
  parameter int unsigned W = OFS_W
) (
  input  logic [1:0]   base_kind,
  input  logic         ovr_en,
  input  logic [1:0]   ovr_sel,
  input  logic [W-1:0] seg_data,
  input  logic [W-1:0] seg_stack,
  input  logic [W-1:0] seg_code,
  input  logic [W-1:0] seg_extra,
  output logic [1:0]   seg_id,
  output logic [W-1:0] seg_val
);
  logic [W-1:0] seg_bank [NUM_SEG];
  logic [1:0]   dflt_id;

  // The bank is indexed by the segment code.
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_bank
    if (g == int'(SEG_DATA)) begin : g_d
      assign seg_bank[g] = seg_data;
    end else if (g == int'(SEG_STACK)) begin : g_s
      assign seg_bank[g] = seg_stack;
    end else if (g == int'(SEG_CODE)) begin : g_c
      assign seg_bank[g] = seg_code;
    end else begin : g_e
      assign seg_bank[g] = seg_extra;
    end
  end

  assign dflt_id = (base_kind == BASE_FRAME) ? SEG_STACK : SEG_DATA;
  assign seg_id  = ovr_en ? ovr_sel : dflt_id;
  assign seg_val = seg_bank[seg_id];
endmodule

// File: rtl/agu_phys.sv
module agu_phys
  import agu_pkg::*;
#(
  parameter int unsigned W  = OFS_W,
  parameter int unsigned PW = PA_W
) (
  input  logic [W-1:0]  seg_val,
  input  logic [W-1:0]  ofs,
  output logic [PW-1:0] phys
);
  assign phys = phys_sum(seg_val, ofs);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import agu_pkg::*;
#(
  parameter int unsigned W  = OFS_W,
  parameter int unsigned PW = PA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    base_kind,
  input  logic [1:0]    idx_kind,
  input  logic          disp_en,
  input  logic          disp_wide,
  input  logic [W-1:0]  base_val,
  input  logic [W-1:0]  idx_val,
  input  logic [W-1:0]  disp_val,
  input  logic [W-1:0]  seg_data,
  input  logic [W-1:0]  seg_stack,
  input  logic [W-1:0]  seg_code,
  input  logic [W-1:0]  seg_extra,
  input  logic          ovr_en,
  input  logic [1:0]    ovr_sel,
  output logic          out_valid,
  output logic          mode_err,
  output logic [PW-1:0] phys_addr,
  output logic [W-1:0]  eff_addr,
  output logic [1:0]    seg_used
);
  // Named internal events, observed by the assertions below.
  logic [W-1:0]  ea_comb;
  logic          mode_bad;
  logic          disp_only;
  logic [1:0]    seg_id_comb;
  logic [W-1:0]  seg_val_comb;
  logic [PW-1:0] phys_comb;
  logic          accept;
  logic          reject;

  agu_ea #(.W(W)) u_ea (
    .base_kind (base_kind),
    .idx_kind  (idx_kind),
    .disp_en   (disp_en),
    .disp_wide (disp_wide),
    .base_val  (base_val),
    .idx_val   (idx_val),
    .disp_val  (disp_val),
    .ea        (ea_comb),
    .mode_bad  (mode_bad),
    .disp_only (disp_only)
  );

  agu_segsel #(.W(W)) u_seg (
    .base_kind (base_kind),
    .ovr_en    (ovr_en),
    .ovr_sel   (ovr_sel),
    .seg_data  (seg_data),
    .seg_stack (seg_stack),
    .seg_code  (seg_code),
    .seg_extra (seg_extra),
    .seg_id    (seg_id_comb),
    .seg_val   (seg_val_comb)
  );

  agu_phys #(.W(W), .PW(PW)) u_phys (
    .seg_val (seg_val_comb),
    .ofs     (ea_comb),
    .phys    (phys_comb)
  );

  assign accept = in_valid && !mode_bad;
  assign reject = in_valid && mode_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mode_err  <= 1'b0;
      phys_addr <= '0;
      eff_addr  <= '0;
      seg_used  <= SEG_DATA;
    end else begin
      out_valid <= accept;
      mode_err  <= reject;
      if (accept) begin
        phys_addr <= phys_comb;
        eff_addr  <= ea_comb;
        seg_used  <= seg_id_comb;
      end
    end
  end

  // R9: an error pulse and a valid pulse never occur together.
  a_r9_err_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && mode_err));

  // R9: a request with no address term at all is flagged.
  a_r9_no_term_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && base_kind == BASE_NONE && idx_kind == IDX_NONE && !disp_en) |=> mode_err);

  // R8: a valid result is always preceded by a strobe.
  a_r8_valid_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R5: a legal frame-base mode without an override lands in the stack segment.
  a_r5_frame_defaults_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && base_kind == BASE_FRAME && idx_kind != IDX_RSVD && !ovr_en)
      |=> (out_valid && seg_used == SEG_STACK));

  // R6: an override on a legal request determines the reported segment.
  a_r6_override_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ovr_en) |=> (seg_used == $past(ovr_sel)));

  // R3: the displacement-only mode passes the full displacement through.
  a_r3_disp_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && disp_only) |=> (eff_addr == $past(disp_val)));
endmodule

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  base_kind, idx_kind, ovr_sel;
  logic        disp_en, disp_wide, ovr_en;
  logic [15:0] base_val, idx_val, disp_val;
  logic [15:0] seg_data, seg_stack, seg_code, seg_extra;
  logic        out_valid, mode_err;
  logic [19:0] phys_addr;
  logic [15:0] eff_addr;
  logic [1:0]  seg_used;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  seg_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .base_kind(base_kind), .idx_kind(idx_kind),
    .disp_en(disp_en), .disp_wide(disp_wide),
    .base_val(base_val), .idx_val(idx_val), .disp_val(disp_val),
    .seg_data(seg_data), .seg_stack(seg_stack), .seg_code(seg_code), .seg_extra(seg_extra),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .out_valid(out_valid), .mode_err(mode_err),
    .phys_addr(phys_addr), .eff_addr(eff_addr), .seg_used(seg_used)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One request: drive on a falling edge, let one rising edge register it,
  // then stop the strobe and leave the outputs to be sampled on the next falling edge.
  task automatic issue();
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int exp_ea(input int bk, input int ik, input bit de, input bit dw,
                                input int b, input int i, input int d);
    int sum;
    int dv;
    sum = 0;
    if (bk == 1 || bk == 2) sum += b;
    if (ik == 1 || ik == 2) sum += i;
    if (de) begin
      if (dw || (bk == 0 && ik == 0)) dv = d;
      else dv = (d & 8'hFF) >= 128 ? (d & 8'hFF) - 256 : (d & 8'hFF);
      sum += dv;
    end
    return sum & 32'hFFFF;
  endfunction

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    base_kind = 0; idx_kind = 0; disp_en = 0; disp_wide = 0;
    base_val = 0; idx_val = 0; disp_val = 0; ovr_en = 0; ovr_sel = 0;
    seg_data = 16'h1000; seg_stack = 16'h2000; seg_code = 16'h3000; seg_extra = 16'h4000;
    repeat (3) @(negedge clk);
    check("R10 out_valid after reset", {31'b0, out_valid}, 0);
    check("R10 mode_err after reset", {31'b0, mode_err}, 0);
    rst_n = 1'b1;

    // Worked examples.
    base_kind = 1; idx_kind = 1; disp_en = 0; base_val = 16'h1000; idx_val = 16'h0880;
    issue();
    check("R1 general base plus source ea", eff_addr, 16'h1880);
    check("R5 general base uses data", seg_used, 0);
    check("R7 phys example one", phys_addr, 20'h11880);
    check("R8 valid after one edge", {31'b0, out_valid}, 1);
    @(negedge clk);
    check("R8 valid drops without strobe", {31'b0, out_valid}, 0);

    base_kind = 2; idx_kind = 2; disp_en = 1; disp_wide = 1;
    base_val = 16'h1000; idx_val = 16'h0005; disp_val = 16'h0125;
    issue();
    check("R1 frame base plus dest plus disp ea", eff_addr, 16'h112A);
    check("R5 frame base uses stack", seg_used, 1);
    check("R7 phys example two", phys_addr, 20'h2112A);

    // Offset wrap and physical wrap.
    base_kind = 1; idx_kind = 2; disp_en = 1; disp_wide = 1;
    base_val = 16'hFFF0; idx_val = 16'h0020; disp_val = 16'h0001; seg_data = 16'hFFFF;
    issue();
    check("R4 ea wraps at 16 bits", eff_addr, 16'h0011);
    check("R7 phys wraps at 20 bits", phys_addr, 20'h00001);

    // Narrow displacement versus displacement-only.
    base_kind = 0; idx_kind = 1; disp_en = 1; disp_wide = 0;
    idx_val = 16'h0100; disp_val = 16'h12F0;
    issue();
    check("R2 narrow disp sign extended", eff_addr, 16'h00F0);
    base_kind = 0; idx_kind = 0;
    issue();
    check("R3 disp only ignores narrow flag", eff_addr, 16'h12F0);

    // Illegal: no term.
    disp_en = 0;
    issue();
    check("R9 no term err", {31'b0, mode_err}, 1);
    check("R9 no term no valid", {31'b0, out_valid}, 0);
    check("R9 outputs unchanged on err", eff_addr, 16'h12F0);

    // Sweep.
    for (int p = 0; p < 3; p++) begin
      case (p)
        0: begin base_val = 16'h1234; idx_val = 16'h0456; disp_val = 16'h0080;
                  seg_data = 16'h1000; seg_stack = 16'h2000; seg_code = 16'h3000; seg_extra = 16'h4000; end
        1: begin base_val = 16'hFFF0; idx_val = 16'h0020; disp_val = 16'h80FF;
                  seg_data = 16'hFFFF; seg_stack = 16'hF000; seg_code = 16'hFFF0; seg_extra = 16'h0001; end
        default: begin base_val = 16'h8000; idx_val = 16'h8000; disp_val = 16'h7F7F;
                  seg_data = 16'hABCD; seg_stack = 16'h1357; seg_code = 16'h0000; seg_extra = 16'hEEEE; end
      endcase
      for (int bk = 0; bk < 4; bk++)
        for (int ik = 0; ik < 4; ik++)
          for (int de = 0; de < 2; de++)
            for (int dw = 0; dw < 2; dw++)
              for (int ov = 0; ov < 5; ov++) begin
                bit illegal;
                int e_ea;
                int e_seg;
                int sv;
                base_kind = bk[1:0]; idx_kind = ik[1:0];
                disp_en = de[0]; disp_wide = dw[0];
                ovr_en = (ov < 4); ovr_sel = ov[1:0];
                issue();
                illegal = (bk == 3) || (ik == 3) || (bk == 0 && ik == 0 && de == 0);
                if (illegal) begin
                  check("R9 sweep err", {31'b0, mode_err}, 1);
                  check("R9 sweep no valid", {31'b0, out_valid}, 0);
                end else begin
                  e_ea = exp_ea(bk, ik, de[0], dw[0], int'(base_val), int'(idx_val), int'(disp_val));
                  e_seg = (ov < 4) ? ov : ((bk == 2) ? 1 : 0);
                  case (e_seg)
                    0: sv = int'(seg_data);
                    1: sv = int'(seg_stack);
                    2: sv = int'(seg_code);
                    default: sv = int'(seg_extra);
                  endcase
                  check("R8 sweep valid", {31'b0, out_valid}, 1);
                  if (bk == 0 && ik == 0) check("R3 sweep ea", eff_addr, e_ea);
                  else if (de == 1 && dw == 0) check("R2 sweep ea", eff_addr, e_ea);
                  else check("R1 R4 sweep ea", eff_addr, e_ea);
                  if (ov < 4) check("R6 sweep seg", seg_used, e_seg);
                  else check("R5 sweep seg", seg_used, e_seg);
                  check("R7 sweep phys", phys_addr, (sv * 16 + e_ea) % 1048576);
                end
              end
    end

    @(negedge clk);
    check("R8 idle no valid", {31'b0, out_valid}, 0);
    check("R9 idle no err", {31'b0, mode_err}, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule